// File: doc/BRIEF.md
# Rotational Position Latency Timer

This block tracks the angular position of a head-per-track disk as a free-running word-position counter. One track holds a fixed number of words, 2048 by default, so the counter wraps at that count. The counter advances by one word slot every programmable number of clock cycles. The current position is exported so that a register file can present it to software as a read-only value. A one-cycle slot tick marks each word boundary, and a transfer engine elsewhere uses it to pace its data moves.

When the controller asks for a transfer, it presents the target disk address and pulses a start request. The block keeps only the low address bits that select a word within a track. It computes how many whole word slots must pass before that word comes round under the heads, using a distance that wraps around the track. When the target word arrives, it raises a one-cycle done strobe. While a wait is pending, the block ignores further start requests. A synchronous reset puts the position back at zero and drops any pending wait.

Top module: `rot_latency_timer`

## Requirements
- R1: On the cycle after a synchronous reset (rst_n low at a clock edge), pos_o is 0, busy_o is 0 and done_o is 0. This holds even if a wait was pending when the reset arrived.
- R2: While period_i holds a constant value P, slot_tick_o pulses for one cycle every P clock cycles.
- R3: pos_o advances by exactly one at each clock edge where slot_tick_o is high. It wraps from 2047 to 0. It holds its value at every other edge. The block has no way to write the position.
- R4: A start_i pulse taken while busy_o is low sets busy_o on the next cycle. The wait, in word slots, is d = (target_i[10:0] − p) mod 2048. Here p is the position after the accepting edge: pos_o + 1 if slot_tick_o is high in that cycle, otherwise pos_o.
- R5: done_o is high for exactly one cycle. This happens on the (d+1)-th slot tick after acceptance, and at that tick pos_o equals target_i[10:0] as it was at acceptance. busy_o is low on the following cycle.
- R6: With period_i held at P, done_o comes exactly d·P cycles after the first slot tick that follows acceptance.
- R7: If target_i[10:0] equals the effective position p, the wait is zero slots, and done_o fires on the first slot tick after acceptance.
- R8: A start_i pulse while busy_o is high has no effect. This includes the cycle in which done_o is high. The pending wait finishes at the same tick and position it would have had without the pulse.
- R9: Only target_i[10:0] takes part in the distance. Higher address bits have no effect on when done_o fires.
- R10: period_i must never be zero. A period of 1 gives a slot tick on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | 16 | Clock cycles per word slot, non-zero |
| start_i | input | 1 | Request to wait for target_i |
| target_i | input | 16 | Disk word address; the low 11 bits select the word in a track |
| pos_o | output | 11 | Current rotational word position |
| slot_tick_o | output | 1 | One-cycle pulse at each word-slot boundary |
| busy_o | output | 1 | A wait is pending |
| done_o | output | 1 | One-cycle strobe when the target word arrives |

## Verification
The two functions that can share a cycle are the slot tick that moves the position and the acceptance of a start request. When both happen at the same edge, the distance must be measured from the already-advanced position. With a period of 1, every start lands on a tick. The bench drives two directed starts in that setting. One targets the next position and must finish on the first tick. The other targets the stale position and must take a full 2047-slot lap. Randomized periods and targets then cover the general case. For every start, a bench model computes the slot distance from the observed pre-edge position and tick. Each done strobe is judged on its tick count, its elapsed cycles and the position at which it fires.

// File: rtl/rpl_pkg.sv
// Package: shared types for the rotational position latency timer.
// Assumes: nothing beyond IEEE 1800-2017.
package rpl_pkg;
    // State of the wait engine
    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_e;
endpackage

// File: rtl/rpl_slot_divider.sv
// Module: rpl_slot_divider
// Divides the clock into word slots. It emits one tick every period_i cycles.
// Assumes: period_i is non-zero. A zero is treated as one so the counter can
// never stall. If period_i is lowered mid-slot, the tick comes at once.
module rpl_slot_divider #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] last_cnt;

    // Last count value of a slot
    always_comb begin
        last_cnt = (period_i == '0) ? '0 : period_i - PERIOD_W'(1);
    end

    assign tick_o = (cnt_q >= last_cnt);

    // Cycle counter within the current word slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PERIOD_W'(1);
        end
    end

    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_i != '0); // R10
    AST_SINGLE_TICK_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == PERIOD_W'(1)) |-> tick_o); // R10
endmodule

// File: rtl/rpl_position_counter.sv
// Module: rpl_position_counter
// Holds the angular word position. It steps by one on each slot tick and
// wraps modulo 2**POS_W.
// Assumes: the words per track is a power of two, so the wrap is the natural
// overflow of the register. There is no write path to the position.
module rpl_position_counter #(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_o
);
    logic [POS_W-1:0] pos_q;

    // Advance the position one word per slot tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tick_i) begin
            pos_q <= pos_q + POS_W'(1);
        end
    end

    assign pos_o = pos_q;

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pos_o == $past(pos_o) + POS_W'(1)); // R3
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(pos_o)); // R3
endmodule

// File: rtl/rpl_wait_engine.sv
// Module: rpl_wait_engine
// Accepts a start request, measures the wrapped distance from the position
// after the current edge to the target word, and counts slot ticks down to
// it. It raises done for one cycle on the tick at which the target passes
// under the heads.
// Assumes: ADDR_W >= POS_W. Starts that arrive while a wait is pending are
// dropped.
module rpl_wait_engine
    import rpl_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              busy_o,
    output logic              done_o
);
    eng_state_e       state_q;
    logic [POS_W-1:0] slots_q;
    logic [POS_W-1:0] tgt_q;
    logic [POS_W-1:0] pos_eff;
    logic [POS_W-1:0] delta;

    // Position as it will stand after this edge, and the wrapped distance to it
    always_comb begin
        pos_eff = tick_i ? pos_i + POS_W'(1) : pos_i;
        delta   = target_i[POS_W-1:0] - pos_eff;
    end

    // Accept a start when idle, then count slots down to the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            slots_q <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        state_q <= ENG_WAIT;
                        slots_q <= delta;
                        tgt_q   <= target_i[POS_W-1:0];
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (slots_q == '0) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            slots_q <= slots_q - POS_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q == ENG_WAIT);
    assign done_o = busy_o && tick_i && (slots_q == '0);

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R4
    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pos_i == tgt_q)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(tgt_q)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !busy_o); // R1
endmodule

// File: rtl/rot_latency_timer.sv
// Module: rot_latency_timer (top)
// Rotational position latency timer: a slot divider, a word-position counter
// and a wait engine that strobes done when a requested word comes round.
// Assumes: WORDS_PER_TRACK is a power of two, and period_i stays non-zero.
module rot_latency_timer #(
    parameter int WORDS_PER_TRACK = 2048,
    parameter int PERIOD_W        = 16,
    parameter int ADDR_W          = 16,
    localparam int POS_W          = $clog2(WORDS_PER_TRACK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   target_i,
    output logic [POS_W-1:0]    pos_o,
    output logic                slot_tick_o,
    output logic                busy_o,
    output logic                done_o
);
    logic tick;

    rpl_slot_divider #(.PERIOD_W(PERIOD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .tick_o   (tick)
    );

    rpl_position_counter #(.POS_W(POS_W)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .pos_o  (pos_o)
    );

    rpl_wait_engine #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .pos_i    (pos_o),
        .start_i  (start_i),
        .target_i (target_i),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    assign slot_tick_o = tick;

    AST_TRACK_POW2: assert property (@(posedge clk)
        (1 << POS_W) == WORDS_PER_TRACK); // R3
endmodule

// File: tb/rot_latency_timer_bench.sv
module rot_latency_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] period_i;
    logic        start_i;
    logic [15:0] target_i;
    logic [10:0] pos_o;
    logic        slot_tick_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk; // 125 MHz

    rot_latency_timer u_rot_latency_timer (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .start_i(start_i),
        .target_i(target_i), .pos_o(pos_o), .slot_tick_o(slot_tick_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int slot_dist(input int tgt, input int p);
        return (tgt - p) & 2047;
    endfunction

    // ---------------- model and monitor (samples at negedge) ----------------
    int  prev_pos = 0;
    bit  prev_tick = 0;
    bit  have_prev = 0;
    bit  pend_r1 = 0;
    int  last_tick_cyc = 0;
    bit  last_tick_ok = 0;
    int  period_seen = 0;
    bit  m_busy = 0;
    int  m_left = 0;
    int  m_d = 0;
    int  m_tgt = 0;
    int  m_period = 0;
    bit  m_p_ok = 0;
    bit  m_ignored = 0;
    bit  m_hi_bits = 0;
    int  first_tick = -1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n !== 1'b1) begin
            m_busy = 0; have_prev = 0; pend_r1 = 1; last_tick_ok = 0;
        end else begin
            bit busy_pre;
            bit exp_done;
            if (pend_r1) begin
                chk(pos_o == 0, "R1 pos", pos_o, 0);
                chk(busy_o == 0, "R1 busy", busy_o, 0);
                chk(done_o == 0, "R1 done", done_o, 0);
                pend_r1 = 0;
            end else if (have_prev) begin
                int ep;
                ep = prev_tick ? ((prev_pos + 1) & 2047) : prev_pos;
                if (prev_tick && prev_pos == 2047)
                    chk(pos_o == ep, "R3 wrap", pos_o, ep);
                else
                    chk(pos_o == ep, "R3", pos_o, ep);
            end
            if (int'(period_i) != period_seen) last_tick_ok = 0;
            period_seen = int'(period_i);
            if (slot_tick_o) begin
                if (last_tick_ok)
                    chk(cyc - last_tick_cyc == int'(period_i),
                        (period_i == 1) ? "R10" : "R2", cyc - last_tick_cyc, int'(period_i));
                last_tick_cyc = cyc;
                last_tick_ok = 1;
            end
            chk(busy_o == m_busy, "R4 busy", busy_o, m_busy);
            if (m_busy && int'(period_i) != m_period) m_p_ok = 0;
            exp_done = m_busy && slot_tick_o && (m_left == 0);
            chk(done_o == exp_done, m_ignored ? "R8 done" : "R5 done", done_o, exp_done);
            if (done_o && exp_done) begin
                chk(int'(pos_o) == m_tgt, m_hi_bits ? "R9 pos" : "R5 pos", pos_o, m_tgt);
                if (m_d == 0)
                    chk(first_tick < 0, "R7 first tick", first_tick, -1);
                else if (m_p_ok)
                    chk(cyc - first_tick == m_d * m_period, "R6", cyc - first_tick, m_d * m_period);
            end
            busy_pre = m_busy;
            if (m_busy && slot_tick_o) begin
                if (m_left == 0) m_busy = 0;
                else begin
                    if (first_tick < 0) first_tick = cyc;
                    m_left--;
                end
            end
            if (start_i && busy_pre) m_ignored = 1;
            if (start_i && !busy_pre) begin
                int pe;
                pe = slot_tick_o ? ((int'(pos_o) + 1) & 2047) : int'(pos_o);
                m_tgt = int'(target_i) & 2047;
                m_d = slot_dist(int'(target_i), pe);
                m_left = m_d;
                m_busy = 1;
                m_period = int'(period_i);
                m_p_ok = 1;
                m_ignored = 0;
                m_hi_bits = (target_i[15:11] != 0);
                first_tick = -1;
            end
            prev_pos = int'(pos_o);
            prev_tick = slot_tick_o;
            have_prev = 1;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse_start(input logic [15:0] tgt);
        start_i = 1'b1; target_i = tgt;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; period_i = 16'd3; start_i = 1'b0; target_i = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;

        // R7 + same-cycle tick: period 1, target is the position after this edge
        period_i = 16'd1;
        @(posedge clk); #1;
        pulse_start(16'(pos_o + 11'd1));
        wait_idle();

        // R4 same-cycle tick: stale position means a full lap of 2047 slots
        @(posedge clk); #1;
        pulse_start(16'(pos_o));
        wait_idle();

        // R9: high address bits set
        period_i = 16'd2;
        repeat (4) @(posedge clk); #1;
        pulse_start(16'hF805);
        wait_idle();

        // R8: extra start during a pending wait
        period_i = 16'd3;
        repeat (4) @(posedge clk); #1;
        pulse_start(16'(pos_o + 11'd300));
        repeat (20) @(posedge clk); #1;
        pulse_start(16'(pos_o + 11'd5));
        wait_idle();

        // R1: reset while a wait is pending
        period_i = 16'd2;
        repeat (3) @(posedge clk); #1;
        pulse_start(16'(pos_o + 11'd1000));
        repeat (50) @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (10) @(posedge clk); #1;

        // Randomized periods and targets
        for (int i = 0; i < 12; i++) begin
            period_i = 16'($urandom_range(1, 3));
            repeat ($urandom_range(1, 7)) @(posedge clk);
            #1;
            pulse_start(16'($urandom));
            if ($urandom_range(0, 1) == 1) begin
                repeat ($urandom_range(1, 30)) @(posedge clk);
                #1;
                if (busy_o) pulse_start(16'($urandom)); // R8
            end
            wait_idle();
        end

        repeat (5) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule